// File: doc/BRIEF.md
# Incrementing Burst Command Splitter

This block sits between a bus port and the command interface of a memory controller core. A bus master opens an incrementing burst of unknown length by pulsing a start strobe with the start address and direction, then moves data one beat at a time and marks the final beat. The splitter turns that open-ended burst into a chain of fixed-size core commands. Each command carries an address, a byte length, a direction and, for writes, a 3-bit urgency tag where 0 is the most urgent.

Two 11-bit byte-count settings, one for reads and one for writes, set the size of every command. All settings are sampled when the burst opens. The bus is stalled while a command waits for the core. Once the last beat of one command has moved and the burst is still going, the splitter raises the next command at the following address. If the master ends the burst part-way through a command, the beats left over in that command are dropped. Read beats the core still has to return are taken in and thrown away. Write beats that were never sent are simply not forwarded.

Write data passes straight to the core in the cycle the bus beat is taken, and the core is assumed to accept it. Read data comes from the core through a valid/ready pair and goes straight to the bus.

Top module: `burst_cmd_splitter`

## Requirements
- R1: While reset is held and in the first cycle after it, cmd_valid, bus_ready, bus_rvalid, cw_valid and cr_ready are all low.
- R2: A bus_start seen while the block is idle raises cmd_valid in the next cycle, with cmd_addr equal to bus_addr and cmd_write equal to bus_write. A bus_start seen while a burst is in progress has no effect.
- R3: Each command covers N beats of BEAT_BYTES (4) bytes. N is the direction's byte count divided by 4 and rounded down, with a minimum of 1. A count of 0 means 1024 bytes (N = 256). cmd_len is N*4, except that a count of 0 is sent as cmd_len 0. A burst of L beats produces exactly ceil(L/N) commands.
- R4: The command after command k is raised in the cycle after the last beat of command k, at start address + (k+1)*N*4. No command is raised after the beat marked bus_last.
- R5: While cmd_valid is high and cmd_ready is low, the command fields stay stable. bus_ready is never high together with cmd_valid.
- R6: In a write burst, each accepted bus beat appears on cw_valid/cw_data in the same cycle. No write beat is forwarded once the burst has ended.
- R7: In a read burst, each accepted bus beat returns the matching core beat on bus_rvalid/bus_rdata. After an early end, the rest of the current command's beats are taken with cr_ready high and bus_rvalid low, and then the block goes idle.
- R8: The counts and the urgency tag in use are the values present at burst start. Changing them mid-burst does not alter the burst in progress.
- R9: cmd_prio equals the write urgency setting on write commands and 0 on read commands. Read commands use the read count and write commands use the write count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_rd_bytes | input | 11 | Bytes per read command (0 = 1024) |
| cfg_wr_bytes | input | 11 | Bytes per write command (0 = 1024) |
| cfg_wr_prio | input | 3 | Urgency tag for write commands, 0 most urgent |
| bus_start | input | 1 | Opens a burst when idle |
| bus_addr | input | 32 | Burst start address |
| bus_write | input | 1 | Burst direction, 1 = write |
| bus_beat_valid | input | 1 | Master offers a beat |
| bus_last | input | 1 | Offered beat is the final beat of the burst |
| bus_wdata | input | 32 | Write beat data |
| bus_ready | output | 1 | Beat is taken this cycle if offered |
| bus_rvalid | output | 1 | Read beat delivered to the master |
| bus_rdata | output | 32 | Read beat data |
| cmd_valid | output | 1 | Command pending for the core |
| cmd_ready | input | 1 | Core accepts the command |
| cmd_addr | output | 32 | Command byte address |
| cmd_len | output | 11 | Command byte length (0 = 1024) |
| cmd_write | output | 1 | Command direction |
| cmd_prio | output | 3 | Command urgency tag |
| cw_valid | output | 1 | Write beat to the core |
| cw_data | output | 32 | Write beat data to the core |
| cr_valid | input | 1 | Core offers a read beat |
| cr_ready | output | 1 | Read beat taken from the core |
| cr_data | input | 32 | Read beat data from the core |

## Verification
The bench sweeps both directions over command sizes that include exact multiples, values below one beat, values that are not multiples of the beat size, and zero. For each size it runs burst lengths that end exactly on a command boundary and lengths that end one beat into or short of one. A design that miscounts the command boundary would issue an extra or a missing command, or put the next command at the wrong address. A design that handles an early read end wrongly would hang in the discard phase or leak discarded beats to the master. The bench also changes settings and pulses start mid-burst, which catches a design that re-samples its inputs during a burst. Zero counts are run with a long burst, which exposes a design that takes zero literally instead of as 1024 bytes.

// File: rtl/bsplit_pkg.sv
// Shared types for the burst command splitter.
package bsplit_pkg;
    // Sequencer phases: idle, command pending, beats moving, read discard.
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_CMD   = 2'd1,
        ST_XFER  = 2'd2,
        ST_DRAIN = 2'd3
    } split_state_t;
endpackage

// File: rtl/bsplit_size.sv
// Converts a programmed byte count into a beat count, a command length and
// an address step. Assumes BEAT_BYTES is a power of two. A count of zero
// means ZERO_BYTES bytes but is still sent to the core as length 0.
module bsplit_size #(
    parameter int CNT_W      = 11,
    parameter int BEAT_BYTES = 4,
    parameter int ZERO_BYTES = 1024
) (
    input  logic [CNT_W-1:0] cnt_i,
    output logic [CNT_W-1:0] beats_o,
    output logic [CNT_W-1:0] len_o,
    output logic [CNT_W-1:0] bytes_o
);
    localparam int SH = $clog2(BEAT_BYTES);
    localparam logic [CNT_W-1:0] ZERO_BEATS = CNT_W'(ZERO_BYTES >> SH);

    logic [CNT_W-1:0] whole;

    // Round down to whole beats, clamp to one beat, map zero to the default.
    always_comb begin
        whole = cnt_i >> SH;
        if (cnt_i == '0)
            beats_o = ZERO_BEATS;
        else if (whole == '0)
            beats_o = CNT_W'(1);
        else
            beats_o = whole;
        bytes_o = beats_o << SH;
        len_o   = (cnt_i == '0) ? '0 : bytes_o;
    end
endmodule

// File: rtl/bsplit_addr.sv
// Command address register: loaded with the burst start address and
// advanced by one command's byte size each time a new command is raised.
module bsplit_addr #(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [ADDR_W-1:0] load_addr_i,
    input  logic              adv_i,
    input  logic [CNT_W-1:0]  step_i,
    output logic [ADDR_W-1:0] addr_o
);
    // Hold, load or step the command address.
    always_ff @(posedge clk) begin
        if (!rst_n)
            addr_o <= '0;
        else if (load_i)
            addr_o <= load_addr_i;
        else if (adv_i)
            addr_o <= addr_o + ADDR_W'(step_i);
    end
endmodule

// File: rtl/bsplit_ctrl.sv
// Burst sequencer. Latches the per-burst settings at start, raises one
// command at a time, counts beats inside the current command, and after an
// early read end discards the core beats left in that command. Assumes the
// core takes every write beat in the cycle it is offered.
module bsplit_ctrl
    import bsplit_pkg::*;
#(
    parameter int CNT_W  = 11,
    parameter int PRIO_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              write_i,
    input  logic [CNT_W-1:0]  beats_i,
    input  logic [CNT_W-1:0]  len_i,
    input  logic [CNT_W-1:0]  bytes_i,
    input  logic [PRIO_W-1:0] prio_i,
    input  logic              cmd_ready_i,
    input  logic              beat_valid_i,
    input  logic              last_i,
    input  logic              cr_valid_i,
    output logic              cmd_valid_o,
    output logic              bus_ready_o,
    output logic              cw_valid_o,
    output logic              rvalid_o,
    output logic              cr_ready_o,
    output logic              load_o,
    output logic              adv_o,
    output logic              write_o,
    output logic [CNT_W-1:0]  len_o,
    output logic [CNT_W-1:0]  bytes_o,
    output logic [PRIO_W-1:0] prio_o
);
    split_state_t     state_q;
    logic [CNT_W-1:0] beats_q;
    logic [CNT_W-1:0] cnt_q;
    logic             xfer;
    logic             fire;
    logic             cmd_end;

    // Handshake decode for the current phase.
    always_comb begin
        xfer        = (state_q == ST_XFER);
        cmd_valid_o = (state_q == ST_CMD);
        bus_ready_o = xfer && (write_o || cr_valid_i);
        fire        = bus_ready_o && beat_valid_i;
        cw_valid_o  = xfer && write_o && beat_valid_i;
        rvalid_o    = xfer && !write_o && beat_valid_i && cr_valid_i;
        cr_ready_o  = (xfer && !write_o && beat_valid_i) || (state_q == ST_DRAIN);
        cmd_end     = (cnt_q == beats_q - CNT_W'(1));
        load_o      = (state_q == ST_IDLE) && start_i;
        adv_o       = fire && !last_i && cmd_end;
    end

    // Latch the burst settings when a burst opens.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            write_o <= 1'b0;
            beats_q <= CNT_W'(1);
            len_o   <= '0;
            bytes_o <= '0;
            prio_o  <= '0;
        end else if (load_o) begin
            write_o <= write_i;
            beats_q <= beats_i;
            len_o   <= len_i;
            bytes_o <= bytes_i;
            prio_o  <= prio_i;
        end
    end

    // Phase sequencing and beat counting inside the current command.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else begin
            case (state_q)
                ST_IDLE: if (start_i) begin
                    state_q <= ST_CMD;
                    cnt_q   <= '0;
                end
                ST_CMD: if (cmd_ready_i) state_q <= ST_XFER;
                ST_XFER: if (fire) begin
                    if (last_i) begin
                        if (write_o || cmd_end) begin
                            state_q <= ST_IDLE;
                            cnt_q   <= '0;
                        end else begin
                            state_q <= ST_DRAIN;
                            cnt_q   <= cnt_q + CNT_W'(1);
                        end
                    end else if (cmd_end) begin
                        state_q <= ST_CMD;
                        cnt_q   <= '0;
                    end else begin
                        cnt_q <= cnt_q + CNT_W'(1);
                    end
                end
                ST_DRAIN: if (cr_valid_i) begin
                    if (cmd_end) begin
                        state_q <= ST_IDLE;
                        cnt_q   <= '0;
                    end else begin
                        cnt_q <= cnt_q + CNT_W'(1);
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // R5
    cmd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid_o && !cmd_ready_i |=> cmd_valid_o && $stable(len_o) && $stable(write_o));
    // R5
    ready_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(cmd_valid_o && bus_ready_o));
    // R3
    beat_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_IDLE) |-> (cnt_q < beats_q));
    // R7
    drain_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DRAIN) |-> (!rvalid_o && !bus_ready_o && cr_ready_o));
    // R6
    wr_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cw_valid_o |-> (write_o && bus_ready_o));
endmodule

// File: rtl/burst_cmd_splitter.sv
// Top level: splits an incrementing bus burst into fixed-size commands for a
// memory controller core. One size decoder per direction; the one for the
// burst's direction is latched at start. Read and write data pass through.
module burst_cmd_splitter #(
    parameter int ADDR_W     = 32,
    parameter int DATA_W     = 32,
    parameter int CNT_W      = 11,
    parameter int PRIO_W     = 3,
    parameter int ZERO_BYTES = 1024
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CNT_W-1:0]  cfg_rd_bytes,
    input  logic [CNT_W-1:0]  cfg_wr_bytes,
    input  logic [PRIO_W-1:0] cfg_wr_prio,
    input  logic              bus_start,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_write,
    input  logic              bus_beat_valid,
    input  logic              bus_last,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic              bus_ready,
    output logic              bus_rvalid,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              cmd_valid,
    input  logic              cmd_ready,
    output logic [ADDR_W-1:0] cmd_addr,
    output logic [CNT_W-1:0]  cmd_len,
    output logic              cmd_write,
    output logic [PRIO_W-1:0] cmd_prio,
    output logic              cw_valid,
    output logic [DATA_W-1:0] cw_data,
    input  logic              cr_valid,
    output logic              cr_ready,
    input  logic [DATA_W-1:0] cr_data
);
    localparam int BEAT_BYTES = DATA_W / 8;
    localparam int NDIR       = 2;

    logic [CNT_W-1:0]  dir_cnt   [NDIR];
    logic [CNT_W-1:0]  dir_beats [NDIR];
    logic [CNT_W-1:0]  dir_len   [NDIR];
    logic [CNT_W-1:0]  dir_bytes [NDIR];
    logic [PRIO_W-1:0] start_prio;
    logic [CNT_W-1:0]  step;
    logic              load;
    logic              adv;

    // Index 0 holds the read setting, index 1 the write setting.
    always_comb begin
        dir_cnt[0] = cfg_rd_bytes;
        dir_cnt[1] = cfg_wr_bytes;
        start_prio = bus_write ? cfg_wr_prio : '0;
    end

    for (genvar g = 0; g < NDIR; g++) begin : g_size
        bsplit_size #(
            .CNT_W     (CNT_W),
            .BEAT_BYTES(BEAT_BYTES),
            .ZERO_BYTES(ZERO_BYTES)
        ) u_size (
            .cnt_i  (dir_cnt[g]),
            .beats_o(dir_beats[g]),
            .len_o  (dir_len[g]),
            .bytes_o(dir_bytes[g])
        );
    end

    bsplit_ctrl #(
        .CNT_W (CNT_W),
        .PRIO_W(PRIO_W)
    ) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (bus_start),
        .write_i     (bus_write),
        .beats_i     (dir_beats[bus_write]),
        .len_i       (dir_len[bus_write]),
        .bytes_i     (dir_bytes[bus_write]),
        .prio_i      (start_prio),
        .cmd_ready_i (cmd_ready),
        .beat_valid_i(bus_beat_valid),
        .last_i      (bus_last),
        .cr_valid_i  (cr_valid),
        .cmd_valid_o (cmd_valid),
        .bus_ready_o (bus_ready),
        .cw_valid_o  (cw_valid),
        .rvalid_o    (bus_rvalid),
        .cr_ready_o  (cr_ready),
        .load_o      (load),
        .adv_o       (adv),
        .write_o     (cmd_write),
        .len_o       (cmd_len),
        .bytes_o     (step),
        .prio_o      (cmd_prio)
    );

    bsplit_addr #(
        .ADDR_W(ADDR_W),
        .CNT_W (CNT_W)
    ) u_addr (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (load),
        .load_addr_i(bus_addr),
        .adv_i      (adv),
        .step_i     (step),
        .addr_o     (cmd_addr)
    );

    // Data paths pass straight through; the sequencer gates the strobes.
    always_comb begin
        cw_data   = bus_wdata;
        bus_rdata = cr_data;
    end

    // R5
    addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && !cmd_ready |=> $stable(cmd_addr) && $stable(cmd_prio));
    // R9
    rd_prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && !cmd_write |-> (cmd_prio == '0));
    // R6
    rd_no_wbeat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_write |-> !cw_valid);
endmodule

// File: tb/burst_cmd_splitter_bench.sv
module burst_cmd_splitter_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [10:0] cfg_rd_bytes = '0;
    logic [10:0] cfg_wr_bytes = '0;
    logic [2:0]  cfg_wr_prio = '0;
    logic        bus_start = 1'b0;
    logic [31:0] bus_addr = '0;
    logic        bus_write = 1'b0;
    logic        bus_beat_valid = 1'b0;
    logic        bus_last = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic        bus_ready, bus_rvalid;
    logic [31:0] bus_rdata;
    logic        cmd_valid;
    logic        cmd_ready = 1'b0;
    logic [31:0] cmd_addr;
    logic [10:0] cmd_len;
    logic        cmd_write;
    logic [2:0]  cmd_prio;
    logic        cw_valid;
    logic [31:0] cw_data;
    logic        cr_valid = 1'b0;
    logic        cr_ready;
    logic [31:0] cr_data = '0;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    burst_cmd_splitter u_burst_cmd_splitter (
        .clk(clk), .rst_n(rst_n),
        .cfg_rd_bytes(cfg_rd_bytes), .cfg_wr_bytes(cfg_wr_bytes), .cfg_wr_prio(cfg_wr_prio),
        .bus_start(bus_start), .bus_addr(bus_addr), .bus_write(bus_write),
        .bus_beat_valid(bus_beat_valid), .bus_last(bus_last), .bus_wdata(bus_wdata),
        .bus_ready(bus_ready), .bus_rvalid(bus_rvalid), .bus_rdata(bus_rdata),
        .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_addr(cmd_addr),
        .cmd_len(cmd_len), .cmd_write(cmd_write), .cmd_prio(cmd_prio),
        .cw_valid(cw_valid), .cw_data(cw_data),
        .cr_valid(cr_valid), .cr_ready(cr_ready), .cr_data(cr_data)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic int beats_of(input int cnt);
        if (cnt == 0) return 256;
        if (cnt / 4 == 0) return 1;
        return cnt / 4;
    endfunction

    function automatic logic [31:0] pat(input int seed, input int i);
        return 32'hA500_0000 ^ (32'(seed) << 12) ^ (32'(i) * 32'h0101_0101);
    endfunction

    // Runs one burst of len_b beats, acting as both bus master and core.
    task automatic run_burst(input bit wr, input int rdc, input int wrc, input int prio,
                             input int len_b, input int dly, input bit gaps,
                             input bit poke, input int seed);
        int n = beats_of(wr ? wrc : rdc);
        int exp_len = ((wr ? wrc : rdc) == 0) ? 0 : n * 4;
        logic [31:0] base = 32'h0010_0000 + 32'(seed) * 32'h0000_4000;
        int idx = 0, acc = 0, given = 0, waitc = 0, cyc = 0;
        bit seen = 1'b0;
        bit bv, f_cmd, f_beat, f_cr;
        cfg_rd_bytes = 11'(rdc);
        cfg_wr_bytes = 11'(wrc);
        cfg_wr_prio  = 3'(prio);
        @(negedge clk);
        bus_start = 1'b1; bus_addr = base; bus_write = wr;
        @(negedge clk);
        bus_start = 1'b0;
        chk(cmd_valid && cmd_addr == base && cmd_write == wr, "R2", "command raised at start",
            {cmd_valid, cmd_write, cmd_addr[29:0]}, {1'b1, wr, base[29:0]});
        while (!(idx == len_b && (wr || given == acc * n))) begin
            if (cyc > 3000) begin
                chk(1'b0, "R7", "burst did not complete", 32'(idx), 32'(len_b));
                break;
            end
            if (cyc != 0) @(negedge clk);
            if (cmd_valid) begin
                if (!seen) begin
                    chk(cmd_addr == base + 32'(acc * n * 4), "R4", "command address",
                        cmd_addr, base + 32'(acc * n * 4));
                    chk(cmd_len == 11'(exp_len), "R3", "command length", 32'(cmd_len), 32'(exp_len));
                    chk(cmd_write == wr, "R9", "command direction", 32'(cmd_write), 32'(wr));
                    chk(cmd_prio == (wr ? 3'(prio) : 3'd0), "R9", "command urgency",
                        32'(cmd_prio), wr ? 32'(prio) : 32'd0);
                    seen = 1'b1;
                end
                cmd_ready = (waitc >= dly);
                waitc++;
            end else begin
                cmd_ready = 1'b0;
            end
            bv = (idx < len_b) && !(gaps && (cyc % 3 == 2));
            bus_beat_valid = bv;
            bus_wdata = pat(seed, idx);
            bus_last = (idx == len_b - 1);
            cr_valid = !wr && (given < acc * n) && !(gaps && (cyc % 4 == 3));
            cr_data = pat(seed, given);
            if (poke && cyc == 3) begin
                bus_start = 1'b1; bus_addr = 32'hDEAD_0000; bus_write = !wr;
                cfg_rd_bytes = 11'd8; cfg_wr_bytes = 11'd12; cfg_wr_prio = 3'(prio + 1);
            end else begin
                bus_start = 1'b0;
            end
            #1;
            chk(!(cmd_valid && bus_ready), "R5", "ready while command pending",
                {31'd0, bus_ready}, 32'd0);
            if (bus_ready && bv) begin
                if (wr)
                    chk(cw_valid && cw_data == pat(seed, idx), "R6", "write beat forwarded",
                        cw_data, pat(seed, idx));
                else
                    chk(bus_rvalid && bus_rdata == pat(seed, idx), "R7", "read beat returned",
                        bus_rdata, pat(seed, idx));
            end
            if (!wr && idx >= len_b && cr_valid)
                chk(cr_ready && !bus_rvalid, "R7", "discard beat",
                    {30'd0, cr_ready, bus_rvalid}, 32'd2);
            f_cmd  = cmd_valid && cmd_ready;
            f_beat = bus_ready && bv;
            f_cr   = cr_valid && cr_ready;
            @(posedge clk);
            if (f_cmd) begin acc++; seen = 1'b0; waitc = 0; end
            if (f_beat) idx++;
            if (f_cr) given++;
            cyc++;
        end
        @(negedge clk);
        bus_start = 1'b0; cmd_ready = 1'b0; cr_valid = 1'b0;
        bus_beat_valid = wr; bus_last = 1'b0;
        cfg_rd_bytes = 11'(rdc); cfg_wr_bytes = 11'(wrc); cfg_wr_prio = 3'(prio);
        for (int i = 0; i < 3; i++) begin
            #1;
            chk(!cmd_valid, "R4", "no command after burst end", {31'd0, cmd_valid}, 32'd0);
            chk(!cw_valid && !bus_ready && !cr_ready, "R6", "quiet after burst end",
                {29'd0, cw_valid, bus_ready, cr_ready}, 32'd0);
            @(negedge clk);
        end
        bus_beat_valid = 1'b0;
        chk(acc == (len_b + n - 1) / n, "R3", "command count", 32'(acc), 32'((len_b + n - 1) / n));
    endtask

    initial begin
        int lens [7] = '{1, 2, 3, 4, 5, 7, 9};
        int cnts [7] = '{4, 8, 12, 2, 7, 0, 13};
        int seed = 0;
        repeat (3) begin
            @(negedge clk);
            chk(!cmd_valid && !bus_ready && !bus_rvalid && !cw_valid && !cr_ready, "R1",
                "outputs in reset", {27'd0, cmd_valid, bus_ready, bus_rvalid, cw_valid, cr_ready}, 32'd0);
        end
        rst_n = 1'b1;
        @(negedge clk);
        chk(!cmd_valid && !bus_ready && !bus_rvalid && !cw_valid && !cr_ready, "R1",
            "outputs after reset", {27'd0, cmd_valid, bus_ready, bus_rvalid, cw_valid, cr_ready}, 32'd0);
        for (int d = 0; d < 2; d++) begin
            for (int c = 0; c < 7; c++) begin
                for (int l = 0; l < 7; l++) begin
                    seed++;
                    // Opposite direction gets a different count to expose a wrong pick (R9).
                    run_burst(d == 1, (d == 1) ? 16 : cnts[c], (d == 1) ? cnts[c] : 20,
                              (c + l) % 8, lens[l], lens[l] % 3, (l % 2) == 1,
                              lens[l] >= 4, seed);
                end
            end
        end
        // R8 mid-burst changes and R3 zero count with a long burst, both directions.
        seed++; run_burst(1'b0, 0, 8, 5, 300, 1, 1'b1, 1'b1, seed);
        seed++; run_burst(1'b1, 8, 0, 6, 300, 2, 1'b1, 1'b1, seed);
        seed++; run_burst(1'b0, 12, 4, 2, 4, 0, 1'b0, 1'b0, seed);
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule